// File: doc/BRIEF.md
# Symbol-Pair Line State Detector

This block watches a receive stream of 5-bit line symbols, delivered two at a time as one pair per byte clock, and decides what the far end is sending. It tells apart a dead link (signal detect low), the three handshake patterns used during connection setup (Halt-Quiet, Halt-Halt, Quiet-Quiet), a run of corrupt symbols (noise), ordinary traffic made of valid idle and delimiter symbols (reported as one "other" class), and an undecided state entered on any pair that does not fit the current state.

Each pair is sorted into a class by comparing its two symbols against fixed codes. A single run counter measures how many accepted pairs of the same class have arrived in a row. A state is entered once its run length is reached. The new state is shown on `line_state` one cycle after the deciding pair is accepted. `state_chg` pulses in the same cycle. The pair input is a valid/ready stream, but the block never applies back-pressure: `pair_ready` is high in every cycle, so a pair is accepted in each cycle where `pair_valid` is high. Cycles with `pair_valid` low carry no pair.

Top module: `pair_linestate_detector`

## Requirements
- R1: While `rst_n` is low, `line_state` is 0 (Unknown) and `state_chg` is 0. The `line_state` codes are: 0 Unknown, 1 No Signal, 2 Master, 3 Halt, 4 Quiet, 5 Noise, 6 Other.
- R2: When `run_en` is low, `line_state` is Unknown from the next cycle on. While `run_en` is low, pairs are ignored and the current run is discarded.
- R3: When `run_en` is high and `sig_det` is low, `line_state` is No Signal from the next cycle on. While this holds, pairs are ignored and the current run is discarded.
- R4: The 8th consecutive pair with first symbol Halt (00100, bits [9:5]) and second symbol Quiet (00000, bits [4:0]) gives Master in the next cycle.
- R5: The 8th consecutive Halt-Halt pair gives Halt in the next cycle.
- R6: The 8th consecutive Quiet-Quiet pair gives Quiet in the next cycle.
- R7: A pair counts as noise when either symbol lies outside the set {00000, 00100, 11111, 11000, 10001}. Noise pairs may differ in value. The 16th consecutive noise pair gives Noise in the next cycle.
- R8: A pair made only of valid symbols that is not Halt-Quiet, Halt-Halt or Quiet-Quiet is of class Other. The 4th consecutive such pair gives Other (6) in the next cycle.
- R9: While in Master, Halt, Quiet, Noise, Other or No Signal, an accepted pair of a different class gives Unknown in the next cycle.
- R10: A change of pair class restarts the run at one. Cycles with `pair_valid` low leave both the run and `line_state` unchanged. The run counter saturates instead of wrapping.
- R11: `state_chg` is high for exactly the cycles in which `line_state` differs from its value in the previous cycle. Between pulses, `line_state` holds.
- R12: `pair_ready` is high in every cycle, and every pair offered is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; low forces Unknown |
| sig_det | input | 1 | Signal detect from the receiver |
| pair_valid | input | 1 | A symbol pair is offered this cycle |
| pair_ready | output | 1 | Pair accepted (always high) |
| pair_data | input | 10 | First symbol in [9:5], second symbol in [4:0] |
| line_state | output | 3 | Current line state code |
| state_chg | output | 1 | One-cycle pulse on each state change |

## Verification
Assertions run on every cycle and cover the following:
- forcing to Unknown when run is disabled, and to No Signal when signal detect is lost;
- the fall to Unknown on a pair that does not fit the current state;
- holding the state in cycles with no pair;
- the agreement between `state_chg` and actual state changes;
- the restart and saturation of the run counter.

Only the bench scenarios can show the following:
- that each state is entered on exactly the right pair count;
- that a run survives gaps in the stream;
- that a run is discarded by a class change, by loss of signal or by disabling run;
- that differing noise values still form one run.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int SYM_W = 5;

  localparam logic [SYM_W-1:0] SYM_QUIET = 5'b00000;
  localparam logic [SYM_W-1:0] SYM_HALT  = 5'b00100;
  localparam logic [SYM_W-1:0] SYM_IDLE  = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J     = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K     = 5'b10001;

  typedef enum logic [2:0] {
    LS_UNK    = 3'd0,
    LS_NOSIG  = 3'd1,
    LS_MASTER = 3'd2,
    LS_HALT   = 3'd3,
    LS_QUIET  = 3'd4,
    LS_NOISE  = 3'd5,
    LS_OTHER  = 3'd6
  } line_state_e;

  typedef enum logic [2:0] {
    PC_HQ    = 3'd0,
    PC_HH    = 3'd1,
    PC_QQ    = 3'd2,
    PC_NOISE = 3'd3,
    PC_OTHER = 3'd4
  } pair_class_e;

  function automatic logic sym_known(input logic [SYM_W-1:0] s);
    return (s == SYM_QUIET) || (s == SYM_HALT) || (s == SYM_IDLE) ||
           (s == SYM_J) || (s == SYM_K);
  endfunction
endpackage

// File: rtl/lsd_pair_classify.sv
module lsd_pair_classify
  import lsd_pkg::*;
(
  input  logic [2*SYM_W-1:0] pair,
  output pair_class_e        cls
);
  logic [1:0] known, is_q, is_h;

  for (genvar s = 0; s < 2; s++) begin : g_sym
    logic [SYM_W-1:0] sym;
    assign sym      = pair[s*SYM_W +: SYM_W];
    assign known[s] = sym_known(sym);
    assign is_q[s]  = (sym == SYM_QUIET);
    assign is_h[s]  = (sym == SYM_HALT);
  end

  // index 1 = first symbol (upper bits), index 0 = second symbol
  always_comb begin
    if (!(&known))               cls = PC_NOISE;
    else if (is_h[1] && is_q[0]) cls = PC_HQ;
    else if (is_h[1] && is_h[0]) cls = PC_HH;
    else if (is_q[1] && is_q[0]) cls = PC_QQ;
    else                         cls = PC_OTHER;
  end
endmodule

// File: rtl/lsd_run_counter.sv
module lsd_run_counter
  import lsd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  pair_class_e      cls,
  output logic [CNT_W-1:0] run_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             have_q;
  pair_class_e      cls_q;
  logic [CNT_W-1:0] cnt_q;
  logic             same;

  assign same    = have_q && (cls == cls_q);
  assign run_len = !same ? CNT_W'(1) :
                   (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_q <= 1'b0;
      cls_q  <= PC_NOISE;
      cnt_q  <= '0;
    end else if (step) begin
      have_q <= 1'b1;
      cls_q  <= cls;
      cnt_q  <= run_len;
    end
  end

  // R10: a class change restarts the run at one
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !same) |=> (cnt_q == CNT_W'(1)));

  // R10: saturation, never wrap
  assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && same && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/lsd_state_fsm.sv
module lsd_state_fsm
  import lsd_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int MASTER_RUN = 8,
  parameter int HALT_RUN   = 8,
  parameter int QUIET_RUN  = 8,
  parameter int NOISE_RUN  = 16,
  parameter int OTHER_RUN  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             sig_det,
  input  logic             step,
  input  pair_class_e      cls,
  input  logic [CNT_W-1:0] run_len,
  output line_state_e      line_state,
  output logic             state_chg
);
  line_state_e      cur_q, nxt;
  logic             chg_q;
  logic [CNT_W-1:0] thr;
  line_state_e      target;
  logic             fits;

  always_comb begin
    case (cls)
      PC_HQ:    begin thr = CNT_W'(MASTER_RUN); target = LS_MASTER; end
      PC_HH:    begin thr = CNT_W'(HALT_RUN);   target = LS_HALT;   end
      PC_QQ:    begin thr = CNT_W'(QUIET_RUN);  target = LS_QUIET;  end
      PC_NOISE: begin thr = CNT_W'(NOISE_RUN);  target = LS_NOISE;  end
      default:  begin thr = CNT_W'(OTHER_RUN);  target = LS_OTHER;  end
    endcase
  end

  // the accepted pair is consistent with the current state
  always_comb begin
    case (cur_q)
      LS_MASTER: fits = (cls == PC_HQ);
      LS_HALT:   fits = (cls == PC_HH);
      LS_QUIET:  fits = (cls == PC_QQ);
      LS_NOISE:  fits = (cls == PC_NOISE);
      LS_OTHER:  fits = (cls == PC_OTHER);
      LS_UNK:    fits = 1'b1;
      default:   fits = 1'b0;
    endcase
  end

  always_comb begin
    nxt = cur_q;
    if (!run_en)                nxt = LS_UNK;
    else if (!sig_det)          nxt = LS_NOSIG;
    else if (step) begin
      if (run_len >= thr)       nxt = target;
      else if (!fits)           nxt = LS_UNK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= LS_UNK;
      chg_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      chg_q <= (nxt != cur_q);
    end
  end

  assign line_state = cur_q;
  assign state_chg  = chg_q;

  assert_runoff_unknown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (line_state == LS_UNK));

  assert_nosig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !sig_det) |=> (line_state == LS_NOSIG));

  // run lengths are all at least 2, so a foreign pair cannot lock at once
  assert_mismatch_unknown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sig_det && step && cur_q != LS_UNK && !fits) |=> (line_state == LS_UNK));

  assert_gap_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sig_det && !step) |=> $stable(line_state));

  assert_pulse_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |-> (line_state != $past(line_state)));

  assert_hold_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !state_chg |-> $stable(line_state));
endmodule

// File: rtl/pair_linestate_detector.sv
module pair_linestate_detector
  import lsd_pkg::*;
#(
  parameter int MASTER_RUN = 8,
  parameter int HALT_RUN   = 8,
  parameter int QUIET_RUN  = 8,
  parameter int NOISE_RUN  = 16,
  parameter int OTHER_RUN  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         sig_det,
  input  logic         pair_valid,
  output logic         pair_ready,
  input  logic [9:0]   pair_data,
  output logic [2:0]   line_state,
  output logic         state_chg
);
  localparam int MAX_AB  = (MASTER_RUN > HALT_RUN) ? MASTER_RUN : HALT_RUN;
  localparam int MAX_CD  = (QUIET_RUN > NOISE_RUN) ? QUIET_RUN : NOISE_RUN;
  localparam int MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAX_RUN = (MAX_ABCD > OTHER_RUN) ? MAX_ABCD : OTHER_RUN;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  logic             live, step;
  pair_class_e      cls;
  logic [CNT_W-1:0] run_len;
  line_state_e      ls;

  assign pair_ready = 1'b1;
  assign live       = run_en & sig_det;
  assign step       = pair_valid & pair_ready & live;

  lsd_pair_classify u_classify (
    .pair (pair_data),
    .cls  (cls)
  );

  lsd_run_counter #(.CNT_W(CNT_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (~live),
    .step    (step),
    .cls     (cls),
    .run_len (run_len)
  );

  lsd_state_fsm #(
    .CNT_W(CNT_W), .MASTER_RUN(MASTER_RUN), .HALT_RUN(HALT_RUN),
    .QUIET_RUN(QUIET_RUN), .NOISE_RUN(NOISE_RUN), .OTHER_RUN(OTHER_RUN)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .sig_det    (sig_det),
    .step       (step),
    .cls        (cls),
    .run_len    (run_len),
    .line_state (ls),
    .state_chg  (state_chg)
  );

  assign line_state = ls;
endmodule

// File: tb/pair_linestate_detector_bench.sv
`timescale 1ns/1ps
module pair_linestate_detector_bench;
  localparam logic [2:0] UNK = 3'd0, NOSIG = 3'd1, MASTER = 3'd2, HALT = 3'd3,
                         QUIET = 3'd4, NOISE = 3'd5, OTHER = 3'd6;
  localparam logic [9:0] P_HQ = 10'b00100_00000;
  localparam logic [9:0] P_HH = 10'b00100_00100;
  localparam logic [9:0] P_QQ = 10'b00000_00000;
  localparam logic [9:0] P_II = 10'b11111_11111;
  localparam logic [9:0] P_JK = 10'b11000_10001;
  localparam logic [9:0] P_N1 = 10'b00001_00000;
  localparam logic [9:0] P_N2 = 10'b01010_11111;

  logic clk = 1'b0;
  logic rst_n, run_en, sig_det, pair_valid;
  logic [9:0] pair_data;
  logic pair_ready, state_chg;
  logic [2:0] line_state;

  int checks = 0;
  int fails = 0;
  bit summary_done = 1'b0;
  logic [2:0] prev_exp = UNK;
  logic [3:0] q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  pair_linestate_detector u_pair_linestate_detector (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .sig_det(sig_det),
    .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_data(pair_data),
    .line_state(line_state), .state_chg(state_chg)
  );

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  // driver: apply one cycle of stimulus, push the expected result
  task automatic drive(input logic v, input logic [9:0] d, input logic r,
                       input logic s, input logic [2:0] exp, input string tag);
    @(negedge clk);
    pair_valid = v; pair_data = d; run_en = r; sig_det = s;
    @(posedge clk);
    #1;
    q_exp.push_back({exp, exp != prev_exp});
    q_tag.push_back(tag);
    prev_exp = exp;
  endtask

  task automatic send_n(input logic [9:0] d, input int n, input logic [2:0] mid,
                        input logic [2:0] last, input string tag);
    for (int i = 0; i < n; i++)
      drive(1'b1, d, 1'b1, 1'b1, (i == n-1) ? last : mid, tag);
  endtask

  // monitor: compare design results against the scoreboard
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [3:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if ({pair_ready, line_state, state_chg} !== {1'b1, e}) begin
        fails++;
        $display("FAIL %s (R11/R12 incl.): ready/state/chg actual %b/%0d/%b expected 1/%0d/%b",
                 t, pair_ready, line_state, state_chg, e[3:1], e[0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b1; sig_det = 1'b1; pair_valid = 1'b1; pair_data = P_HH;
    repeat (3) @(negedge clk);
    checks++;
    if (line_state !== UNK || state_chg !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %0d/%b expected 0/0", line_state, state_chg);
    end
    checks++;
    if (pair_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 ready: actual %b expected 1", pair_ready);
    end
    rst_n = 1'b1; pair_valid = 1'b0;

    drive(1'b0, P_HQ, 1'b1, 1'b0, NOSIG, "R3 signal lost");
    drive(1'b1, P_HQ, 1'b1, 1'b0, NOSIG, "R3 pair ignored w/o signal");
    send_n(P_HQ, 8, UNK, MASTER, "R4 master on 8th / R9 leave nosig");
    send_n(P_HH, 8, UNK, HALT, "R5 halt on 8th");
    for (int i = 0; i < 3; i++) drive(1'b0, P_QQ, 1'b1, 1'b1, HALT, "R10 gap holds halt");
    drive(1'b1, P_QQ, 1'b1, 1'b1, UNK, "R9 mismatch from halt");
    send_n(P_QQ, 6, UNK, UNK, "R10 quiet run");
    for (int i = 0; i < 2; i++) drive(1'b0, P_HH, 1'b1, 1'b1, UNK, "R10 gap in run");
    drive(1'b1, P_QQ, 1'b1, 1'b1, QUIET, "R6 quiet on 8th across gap");
    send_n(P_HH, 1, UNK, UNK, "R9 mismatch from quiet");
    send_n(P_QQ, 7, UNK, UNK, "R10 class change restarts");
    send_n(P_QQ, 1, UNK, QUIET, "R6 quiet after restart");
    send_n(P_N1, 15, UNK, UNK, "R7 noise run");
    send_n(P_N2, 1, UNK, NOISE, "R7 noise on 16th mixed values");
    send_n(P_N2, 20, NOISE, NOISE, "R10 saturating noise run");
    send_n(P_JK, 2, UNK, UNK, "R8 other run");
    send_n(P_II, 2, UNK, OTHER, "R8 other on 4th");
    send_n(P_HH, 5, UNK, UNK, "R9 mismatch from other");
    for (int i = 0; i < 3; i++) drive(1'b1, P_HH, 1'b0, 1'b1, UNK, "R2 run off");
    send_n(P_HH, 7, UNK, UNK, "R2 run cleared");
    send_n(P_HH, 1, UNK, HALT, "R5 halt after run off");
    send_n(P_QQ, 5, UNK, UNK, "R9 leave halt");
    drive(1'b1, P_QQ, 1'b1, 1'b0, NOSIG, "R3 signal lost clears run");
    send_n(P_QQ, 7, UNK, UNK, "R3 run restarted");
    send_n(P_QQ, 1, UNK, QUIET, "R6 quiet after signal return");
    drive(1'b1, P_QQ, 1'b0, 1'b1, UNK, "R2 run off from quiet");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule